// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Aligner

This block formats data moving between a register port and a little-endian memory data bus that is split into byte lanes. On a store it produces the bus write data and one enable per lane. On a load it takes the memory read data and produces the value written to the destination register. It receives only the low address bits that pick a lane within a word. Address computation, bus handshaking and caching are handled elsewhere.

For byte transfers the block does not shift a store byte into its lane. It copies the low byte of the source onto every lane and enables only the addressed lane. A byte load takes the addressed lane, places it at the bottom of the result and clears all higher bits. Word transfers pass data through unchanged, and a store enables every lane. A word transfer whose low address bits are not zero raises an alignment flag but is still carried out as a word transfer.

All outputs are registered, so a result appears on the clock edge after its inputs are sampled. A parameter can remove this output stage when the block is placed inside a pipeline stage that already registers it. The widths of the data bus and of a lane are parameters, and the lane count and lane-select width are derived from them. The defaults are a 32-bit bus with 8-bit lanes.

Top module: `lsa_aligner`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every output (`bus_wdata`, `bus_lane_we`, `reg_wdata`, `misalign`) is zero.
- R2: A byte load selects read-data bits 7:0 when `addr_lo`=0, bits 15:8 when 1, bits 23:16 when 2 and bits 31:24 when 3.
- R3: A byte load places the selected byte in `reg_wdata[7:0]` and drives `reg_wdata[31:8]` to zero, even when the byte's top bit is set.
- R4: A byte store drives `st_data[7:0]` onto all four 8-bit lanes of `bus_wdata`.
- R5: A byte store drives `bus_lane_we` one-hot, with only bit `addr_lo` set (bit 0 covers bus bits 7:0).
- R6: A word store drives `bus_wdata` equal to `st_data` and `bus_lane_we` = 4'b1111.
- R7: A word load drives `reg_wdata` equal to `rd_data`.
- R8: During any load (`is_store`=0), `bus_lane_we` is 4'b0000 and `bus_wdata` is zero.
- R9: During any store (`is_store`=1), `reg_wdata` is zero.
- R10: `misalign` is 1 exactly when a word transfer (`is_byte`=0) has a nonzero `addr_lo`. Byte transfers and aligned words give 0.
- R11: With the default output stage, each output reflects the inputs sampled at the previous rising clock edge, and back-to-back transfers produce results in the next cycle each.
- R12: A misaligned word transfer is otherwise executed as a word transfer: full pass-through data and, for a store, all lane enables set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_lo | input | 2 | Low address bits selecting the lane |
| is_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| is_store | input | 1 | 1 = store, 0 = load |
| st_data | input | 32 | Source register value for stores |
| rd_data | input | 32 | Memory read data for loads |
| bus_wdata | output | 32 | Memory write data |
| bus_lane_we | output | 4 | Per-lane write enables |
| reg_wdata | output | 32 | Value for the destination register |
| misalign | output | 1 | Word transfer with nonzero low address bits |

## Verification
Byte loads use a read word whose four lanes all hold different values, read at each of the four addresses. A wrong lane select therefore produces a distinct wrong value, and a lane with its top bit set shows whether the upper bits are cleared or sign-extended. Byte stores use a source whose low byte differs from its other bytes. This separates replication of the low byte from a shift of the whole word, and the same store at each address exercises every enable pattern. Word transfers are run both aligned and misaligned, in both directions, to separate the flag from the data path. Transfers are issued back to back with changing modes to expose any leftover state between cycles.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef struct packed {
      logic is_store;
      logic is_byte;
   } lsa_ctrl_t;

   function automatic int unsigned lsa_log2(input int unsigned n);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < n) r++;
      return r;
   endfunction

endpackage

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int SEL_W  = lsa_pkg::lsa_log2(LANES)
) (
   input  lsa_pkg::lsa_ctrl_t ctrl,
   input  logic [SEL_W-1:0]   lane_sel,
   input  logic [DATA_W-1:0]  src,
   output logic [DATA_W-1:0]  wdata,
   output logic [LANES-1:0]   lane_we
);
   logic [DATA_W-1:0] repl;
   logic [LANES-1:0]  dec;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign repl[g*LANE_W +: LANE_W] = src[LANE_W-1:0];
      assign dec[g] = (lane_sel == g[SEL_W-1:0]);
   end

   always_comb begin
      wdata   = '0;
      lane_we = '0;
      if (ctrl.is_store) begin
         if (ctrl.is_byte) begin
            wdata   = repl;
            lane_we = dec;
         end else begin
            wdata   = src;
            lane_we = '1;
         end
      end
   end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int SEL_W  = lsa_pkg::lsa_log2(LANES)
) (
   input  lsa_pkg::lsa_ctrl_t ctrl,
   input  logic [SEL_W-1:0]   lane_sel,
   input  logic [DATA_W-1:0]  rdata,
   output logic [DATA_W-1:0]  result
);
   logic [LANE_W-1:0] lane_arr [LANES];
   logic [LANE_W-1:0] picked;

   for (genvar g = 0; g < LANES; g++) begin : g_split
      assign lane_arr[g] = rdata[g*LANE_W +: LANE_W];
   end

   assign picked = lane_arr[lane_sel];

   always_comb begin
      result = '0;
      if (!ctrl.is_store) begin
         if (ctrl.is_byte) result[LANE_W-1:0] = picked;
         else              result = rdata;
      end
   end
endmodule

// File: rtl/lsa_align_detect.sv
module lsa_align_detect #(
   parameter int SEL_W = 2
) (
   input  lsa_pkg::lsa_ctrl_t ctrl,
   input  logic [SEL_W-1:0]   lane_sel,
   output logic               misalign
);
   assign misalign = !ctrl.is_byte && (|lane_sel);
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner #(
   parameter int DATA_W  = 32,
   parameter int LANE_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int SEL_W  = lsa_pkg::lsa_log2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  addr_lo,
   input  logic              is_byte,
   input  logic              is_store,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [LANES-1:0]  bus_lane_we,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              misalign
);
   if (DATA_W % LANE_W != 0) begin : g_bad_div
      $error("lsa_aligner: DATA_W must be a multiple of LANE_W");
   end
   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("lsa_aligner: lane count must be a power of two of at least 2");
   end

   lsa_pkg::lsa_ctrl_t ctrl;
   assign ctrl.is_store = is_store;
   assign ctrl.is_byte  = is_byte;

   logic [DATA_W-1:0] nx_wdata, nx_rdata;
   logic [LANES-1:0]  nx_we;
   logic              nx_mis;

   lsa_store_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
      .ctrl(ctrl), .lane_sel(addr_lo), .src(st_data),
      .wdata(nx_wdata), .lane_we(nx_we));

   lsa_load_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
      .ctrl(ctrl), .lane_sel(addr_lo), .rdata(rd_data), .result(nx_rdata));

   lsa_align_detect #(.SEL_W(SEL_W)) u_al (
      .ctrl(ctrl), .lane_sel(addr_lo), .misalign(nx_mis));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bus_wdata   <= '0;
            bus_lane_we <= '0;
            reg_wdata   <= '0;
            misalign    <= 1'b0;
         end else begin
            bus_wdata   <= nx_wdata;
            bus_lane_we <= nx_we;
            reg_wdata   <= nx_rdata;
            misalign    <= nx_mis;
         end
      end
   end else begin : g_comb
      assign bus_wdata   = nx_wdata;
      assign bus_lane_we = nx_we;
      assign reg_wdata   = nx_rdata;
      assign misalign    = nx_mis;
   end
endmodule

// File: rtl/lsa_aligner_chk.sv
module lsa_aligner_chk #(
   parameter int DATA_W  = 32,
   parameter int LANE_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int SEL_W  = lsa_pkg::lsa_log2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  addr_lo,
   input logic              is_byte,
   input logic              is_store,
   input logic [DATA_W-1:0] st_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [LANES-1:0]  bus_lane_we,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              misalign
);
   logic [SEL_W-1:0]  c_addr;
   logic              c_byte, c_store, c_ok;
   logic [LANE_W-1:0] c_low;

   if (OUT_REG) begin : g_seen
      logic              seen;
      logic [SEL_W-1:0]  q_addr;
      logic              q_byte, q_store;
      logic [LANE_W-1:0] q_low;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen <= 1'b0; q_addr <= '0; q_byte <= 1'b0; q_store <= 1'b0; q_low <= '0;
         end else begin
            seen <= 1'b1; q_addr <= addr_lo; q_byte <= is_byte;
            q_store <= is_store; q_low <= st_data[LANE_W-1:0];
         end
      end
      assign c_ok = seen; assign c_addr = q_addr; assign c_byte = q_byte;
      assign c_store = q_store; assign c_low = q_low;
   end else begin : g_now
      assign c_ok = 1'b1; assign c_addr = addr_lo; assign c_byte = is_byte;
      assign c_store = is_store; assign c_low = st_data[LANE_W-1:0];
   end

   a_r3_byte_load_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && !c_store && c_byte) |-> reg_wdata[DATA_W-1:LANE_W] == '0);

   a_r4_byte_store_replicate: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && c_store && c_byte) |-> bus_wdata == {LANES{c_low}});

   a_r5_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && c_store && c_byte) |-> ($onehot(bus_lane_we) && bus_lane_we[c_addr]));

   a_r6_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && c_store && !c_byte) |-> bus_lane_we == '1);

   a_r8_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && !c_store) |-> (bus_lane_we == '0 && bus_wdata == '0));

   a_r9_store_no_reg_data: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ok && c_store) |-> reg_wdata == '0);

   a_r10_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      c_ok |-> misalign == (!c_byte && c_addr != '0));
endmodule

bind lsa_aligner lsa_aligner_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .is_byte(is_byte), .is_store(is_store),
   .st_data(st_data), .rd_data(rd_data), .bus_wdata(bus_wdata), .bus_lane_we(bus_lane_we),
   .reg_wdata(reg_wdata), .misalign(misalign));

// File: tb/lsa_aligner_test.sv
module lsa_aligner_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr_lo = '0;
   logic        is_byte = 1'b0, is_store = 1'b0;
   logic [31:0] st_data = '0, rd_data = '0;
   logic [31:0] bus_wdata, reg_wdata;
   logic [3:0]  bus_lane_we;
   logic        misalign;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] wd;
      logic [3:0]  we;
      logic [31:0] rg;
      logic        mis;
      string       req;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   lsa_aligner uut (
      .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .is_byte(is_byte), .is_store(is_store),
      .st_data(st_data), .rd_data(rd_data), .bus_wdata(bus_wdata), .bus_lane_we(bus_lane_we),
      .reg_wdata(reg_wdata), .misalign(misalign));

   task automatic compare(input exp_t e);
      n_cmp++;
      if (bus_wdata !== e.wd || bus_lane_we !== e.we || reg_wdata !== e.rg || misalign !== e.mis) begin
         n_bad++;
         $display("FAIL %s: got wd=%h we=%b rg=%h mis=%b, expected wd=%h we=%b rg=%h mis=%b",
                  e.req, bus_wdata, bus_lane_we, reg_wdata, misalign, e.wd, e.we, e.rg, e.mis);
      end
   endtask

   task automatic xfer(input bit st, input bit byt, input logic [1:0] a,
                       input logic [31:0] sd, input logic [31:0] rd, input string req);
      exp_t e;
      @(negedge clk);
      is_store = st; is_byte = byt; addr_lo = a; st_data = sd; rd_data = rd;
      e.wd = '0; e.we = '0; e.rg = '0;
      e.mis = !byt && (a != 2'd0);
      if (st) begin
         if (byt) begin
            e.wd = {4{sd[7:0]}};
            case (a)
               2'd0: e.we = 4'b0001;
               2'd1: e.we = 4'b0010;
               2'd2: e.we = 4'b0100;
               default: e.we = 4'b1000;
            endcase
         end else begin
            e.wd = sd; e.we = 4'b1111;
         end
      end else begin
         if (byt) begin
            case (a)
               2'd0: e.rg = {24'h0, rd[7:0]};
               2'd1: e.rg = {24'h0, rd[15:8]};
               2'd2: e.rg = {24'h0, rd[23:16]};
               default: e.rg = {24'h0, rd[31:24]};
            endcase
         end else e.rg = rd;
      end
      e.req = req;
      q.push_back(e);
   endtask

   // monitor: result of inputs set at a falling edge appears after the next rising edge (R11)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      if (!done) begin
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      exp_t z;
      z.wd = '0; z.we = '0; z.rg = '0; z.mis = 1'b0; z.req = "R1";
      is_store = 1'b1; is_byte = 1'b0; addr_lo = 2'd3; st_data = 32'hFFFF_FFFF; rd_data = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare(z);                       // R1 during reset
      is_store = 1'b0; is_byte = 1'b0; addr_lo = 2'd0; st_data = '0; rd_data = '0;
      rst_n = 1'b1;
      @(posedge clk); #2;
      compare(z);                       // R1 first clock after reset with idle load inputs

      // R2/R3 byte loads, distinct lanes
      for (int a = 0; a < 4; a++) xfer(0, 1, a[1:0], 32'h0, 32'hA1B2C3D4, "R2_R3");
      // R3 high-bit lanes must not sign-extend
      for (int a = 0; a < 4; a++) xfer(0, 1, a[1:0], 32'hFFFF_FFFF, 32'h80FF7F80, "R3_R8");
      // R4/R5 byte stores
      for (int a = 0; a < 4; a++) xfer(1, 1, a[1:0], 32'h123456F7, 32'hDEADBEEF, "R4_R5_R9");
      // R6/R7 aligned words
      xfer(1, 0, 2'd0, 32'hCAFE_0123, 32'h5555_AAAA, "R6_R9");
      xfer(0, 0, 2'd0, 32'h1111_2222, 32'h8765_4321, "R7_R8");
      // R10/R12 misaligned words, both directions
      for (int a = 1; a < 4; a++) xfer(1, 0, a[1:0], 32'h0BAD_F00D, 32'h0, "R10_R12");
      for (int a = 1; a < 4; a++) xfer(0, 0, a[1:0], 32'h0, 32'h7654_3210, "R10_R12");
      // R10 byte transfers never flag; R11 alternating back-to-back
      xfer(1, 1, 2'd3, 32'h0000_0055, 32'h0, "R10_R11");
      xfer(0, 1, 2'd2, 32'h0, 32'h00EE_0000, "R10_R11");
      xfer(1, 0, 2'd0, 32'h1357_9BDF, 32'h0, "R11");
      xfer(0, 1, 2'd1, 32'hFFFF_FFFF, 32'h0000_9900, "R11");
      @(negedge clk);
      is_store = 1'b0; is_byte = 1'b0; addr_lo = 2'd0; st_data = '0; rd_data = '0;
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R11: got %0d pending results, expected 0", q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule